// File: doc/BRIEF.md
# Dual-Register Programmable Output Cell

This block is one output cell of a small programmable logic fabric. It takes two sum-term signals and the per-register control terms that an AND array upstream produces. It holds two state bits and drives one tri-state pad. Each of the two registers can be set up as a plain data register or as a toggle register. Each one advances on a rising edge of its own clock term or of a shared pin clock. Both registers return their state to the array, but only register 0 can reach the pad. The pad can carry the registered value or a combinational value. That value is built from sum term 0 alone or from both sum terms ORed together, and it can be inverted before the driver.

Everything runs on one system clock. The clock term and the pin clock are sampled on that clock. A register advances on the system clock edge at which its chosen source is 1 and was 0 on the previous edge. Each register has its own reset term, which forces it to 0 immediately. There is also a shared synchronous preset, and a test preload path that writes the pad level into the register picked by a select input. The configuration inputs are captured while reset is asserted. After that they are treated as static.

Top module: `dual_reg_macrocell`

## Requirements
- R1: The cell holds two registers. `fb[0]` and `fb[1]` always carry the true state of register 0 and register 1. Only register 0 can reach `pad_o`.
- R2: A register with its `cfg_toggle` bit at 0 loads its data input on an advance. Register 1's data input is `sum_term[1]`. Register 0's data input is `sum_term[0]`, or `sum_term[0] | sum_term[1]` when `cfg_merge` is 1.
- R3: A register with its `cfg_toggle` bit at 1 inverts its state on an advance when its data input is 1, and keeps its state when its data input is 0.
- R4: When its `cfg_pinclk` bit is 0, a register advances only on its `clk_term` bit. When that bit is 1, it advances only on `pin_clk`. The advance happens on the system clock edge at which the chosen source is 1 and was 0 at the previous edge. With no such edge, the register keeps its value.
- R5: While `areset_term[i]` is 1, `fb[i]` reads 0 in the same cycle. Register i is 0 after the next clock edge. This overrides preload, preset and data updates.
- R6: `pad_oe` equals `oe_term`. `pin_rd` always mirrors `pad_i`, whatever the state of the driver.
- R7: With `cfg_reg_out` at 1, the pad value is register 0. With it at 0, the pad value is register 0's data input as defined in R2.
- R8: `cfg_invert` at 1 inverts `pad_o` and has no effect on `fb`.
- R9: While `preload_mode` is 1, the register chosen by `preload_sel` (0 for register 0, 1 for register 1) loads `pad_i` on its advance edge (R4). The other register keeps its value. Preload overrides preset and data updates.
- R10: When `sync_preset` is 1 on an advance edge outside preload mode, the register becomes 1. This overrides the data or toggle update.
- R11: While `rst_n` is low, both registers are 0 and `pad_o` equals the value in R7 and R8 for a register of 0. The configuration inputs are captured while reset is held. Changes to them after reset has been released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_toggle | input | 2 | Per-register type: 1 = toggle, 0 = data |
| cfg_pinclk | input | 2 | Per-register clock source: 1 = pin clock, 0 = own clock term |
| cfg_reg_out | input | 1 | 1 = pad shows register 0, 0 = combinational |
| cfg_merge | input | 1 | 1 = OR both sum terms into register 0's data input |
| cfg_invert | input | 1 | 1 = invert the pad value |
| sum_term | input | 2 | Sum-term inputs, one per register |
| clk_term | input | 2 | Per-register clock terms |
| pin_clk | input | 1 | Shared pin clock |
| areset_term | input | 2 | Per-register reset terms |
| sync_preset | input | 1 | Shared synchronous preset term |
| oe_term | input | 1 | Output enable term |
| preload_mode | input | 1 | Test preload mode |
| preload_sel | input | 1 | Preload target register |
| pad_i | input | 1 | Level seen on the pad |
| pad_o | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad driver enable |
| pin_rd | output | 1 | Pad level returned to the array |
| fb | output | 2 | Register state feedback |

## Verification
The bench runs every one of the 128 configurations through a random mix of edges, reset terms, presets and preloads. It targets the cases where a rule is outranked: a reset term together with a preload, a preload together with a preset, and an edge on the clock source that is not selected. A design that gets the priority wrong shows up on `fb` as a 1 where a reset or preload value was due. A design that listens to the wrong clock advances when it should hold. Configuration inputs are scrambled after reset, so a design that does not latch them changes mode mid-run. An inversion that leaks into the feedback makes `fb` disagree with the register state the bench expects.

// File: rtl/mc_pkg.sv
package mc_pkg;
  parameter int NREG = 2;
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

  typedef struct packed {
    logic [NREG-1:0] toggle;
    logic [NREG-1:0] pinclk;
    logic            reg_out;
    logic            merge;
    logic            invert;
  } cell_cfg_t;
endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mc_clk_pick.sv
module mc_clk_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic use_pin,
  input  logic own_term,
  input  logic pin_clk,
  output logic tick
);
  logic src;
  logic prev_q;

  always_comb begin
    src  = use_pin ? pin_clk : own_term;
    tick = src & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= src;
  end
endmodule

// File: rtl/mc_flop.sv
module mc_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic toggle,
  input  logic d,
  input  logic areset,
  input  logic spre,
  input  logic pl_mode,
  input  logic pl_hit,
  input  logic pl_data,
  output logic fb
);
  logic q;
  logic q_nxt;
  logic q_en;

  always_comb begin
    q_en  = 1'b0;
    q_nxt = q;
    if (areset) begin
      q_en  = 1'b1;
      q_nxt = 1'b0;
    end else if (run && tick) begin
      if (pl_mode) begin
        q_en  = pl_hit;
        q_nxt = pl_data;
      end else if (spre) begin
        q_en  = 1'b1;
        q_nxt = 1'b1;
      end else begin
        q_en  = 1'b1;
        q_nxt = toggle ? (q ^ d) : d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_nxt;
  end

  assign fb = q & ~areset;
endmodule

// File: rtl/mc_out_path.sv
module mc_out_path
  import mc_pkg::*;
(
  input  cell_cfg_t       cfg,
  input  logic [NREG-1:0] sum_term,
  input  logic            fb0,
  output logic            d0,
  output logic            pad_o
);
  logic sel_val;

  always_comb begin
    d0      = cfg.merge ? (|sum_term) : sum_term[0];
    sel_val = cfg.reg_out ? fb0 : d0;
    pad_o   = sel_val ^ cfg.invert;
  end
endmodule

// File: rtl/dual_reg_macrocell.sv
module dual_reg_macrocell
  import mc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG-1:0]       cfg_toggle,
  input  logic [NREG-1:0]       cfg_pinclk,
  input  logic                  cfg_reg_out,
  input  logic                  cfg_merge,
  input  logic                  cfg_invert,
  input  logic [NREG-1:0]       sum_term,
  input  logic [NREG-1:0]       clk_term,
  input  logic                  pin_clk,
  input  logic [NREG-1:0]       areset_term,
  input  logic                  sync_preset,
  input  logic                  oe_term,
  input  logic                  preload_mode,
  input  logic [SEL_W-1:0]      preload_sel,
  input  logic                  pad_i,
  output logic                  pad_o,
  output logic                  pad_oe,
  output logic                  pin_rd,
  output logic [NREG-1:0]       fb
);
  logic      rst_sync_n;
  cell_cfg_t cfg_in;
  cell_cfg_t cfg_q;
  logic      d0;
  logic [NREG-1:0] din;
  logic [NREG-1:0] tick;

  mc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // Configuration is captured while reset is held, then frozen (R11).
  always_comb begin
    cfg_in.toggle  = cfg_toggle;
    cfg_in.pinclk  = cfg_pinclk;
    cfg_in.reg_out = cfg_reg_out;
    cfg_in.merge   = cfg_merge;
    cfg_in.invert  = cfg_invert;
  end

  always_ff @(posedge clk) begin
    if (!rst_sync_n) cfg_q <= cfg_in;
  end

  mc_out_path u_out (
    .cfg(cfg_q), .sum_term(sum_term), .fb0(fb[0]), .d0(d0), .pad_o(pad_o)
  );

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_d0
        assign din[i] = d0;
      end else begin : g_dn
        assign din[i] = sum_term[i];
      end

      mc_clk_pick u_pick (
        .clk(clk), .rst_n(rst_n), .use_pin(cfg_q.pinclk[i]),
        .own_term(clk_term[i]), .pin_clk(pin_clk), .tick(tick[i])
      );

      mc_flop u_flop (
        .clk(clk), .rst_n(rst_n), .run(rst_sync_n), .tick(tick[i]),
        .toggle(cfg_q.toggle[i]), .d(din[i]), .areset(areset_term[i]),
        .spre(sync_preset), .pl_mode(preload_mode),
        .pl_hit(preload_sel == SEL_W'(i)), .pl_data(pad_i), .fb(fb[i])
      );
    end
  endgenerate

  assign pad_oe = oe_term;
  assign pin_rd = pad_i;
endmodule

// File: rtl/mc_checker.sv
module mc_checker
  import mc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            rst_sync_n,
  input cell_cfg_t       cfg_q,
  input logic [NREG-1:0] clk_term,
  input logic            pin_clk,
  input logic [NREG-1:0] areset_term,
  input logic            sync_preset,
  input logic            preload_mode,
  input logic [SEL_W-1:0] preload_sel,
  input logic            pad_i,
  input logic            pad_o,
  input logic [NREG-1:0] fb
);
  logic [NREG-1:0] src;
  logic [NREG-1:0] src_prev;
  logic [NREG-1:0] rise;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      src[i] = cfg_q.pinclk[i] ? pin_clk : clk_term[i];
    end
    rise = src & ~src_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev <= '0;
    else        src_prev <= src;
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_chk
      assert_areset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        areset_term[i] |=> !fb[i]);

      assert_hold_without_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!areset_term[i] && !rise[i]) |=> (areset_term[i] || fb[i] == $past(fb[i])));

      assert_preset_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_sync_n && rise[i] && !areset_term[i] && !preload_mode && sync_preset)
        |=> (areset_term[i] || fb[i]));

      assert_preload_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_sync_n && rise[i] && !areset_term[i] && preload_mode &&
         preload_sel == SEL_W'(i))
        |=> (areset_term[i] || fb[i] == $past(pad_i)));

      assert_preload_other_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_mode && preload_sel != SEL_W'(i) && !areset_term[i])
        |=> (areset_term[i] || fb[i] == $past(fb[i])));
    end
  endgenerate

  assert_pad_polarity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && cfg_q.reg_out) |-> (pad_o == (fb[0] ^ cfg_q.invert)));
endmodule

bind dual_reg_macrocell mc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n), .cfg_q(cfg_q),
  .clk_term(clk_term), .pin_clk(pin_clk), .areset_term(areset_term),
  .sync_preset(sync_preset), .preload_mode(preload_mode),
  .preload_sel(preload_sel), .pad_i(pad_i), .pad_o(pad_o), .fb(fb)
);

// File: tb/dual_reg_macrocell_bench.sv
`timescale 1ns/1ps
module dual_reg_macrocell_bench;
  logic       clk;
  logic       rst_n;
  logic [1:0] cfg_toggle, cfg_pinclk;
  logic       cfg_reg_out, cfg_merge, cfg_invert;
  logic [1:0] sum_term, clk_term, areset_term;
  logic       pin_clk, sync_preset, oe_term, preload_mode;
  logic [0:0] preload_sel;
  logic       pad_i;
  logic       pad_o, pad_oe, pin_rd;
  logic [1:0] fb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  bit [1:0] m_q, m_prev;
  bit [6:0] m_cfg;   // {toggle[1:0], pinclk[1:0], reg_out, merge, invert}
  string    m_cause [2];

  dual_reg_macrocell u_dual_reg_macrocell (
    .clk(clk), .rst_n(rst_n), .cfg_toggle(cfg_toggle), .cfg_pinclk(cfg_pinclk),
    .cfg_reg_out(cfg_reg_out), .cfg_merge(cfg_merge), .cfg_invert(cfg_invert),
    .sum_term(sum_term), .clk_term(clk_term), .pin_clk(pin_clk),
    .areset_term(areset_term), .sync_preset(sync_preset), .oe_term(oe_term),
    .preload_mode(preload_mode), .preload_sel(preload_sel), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .pin_rd(pin_rd), .fb(fb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit f_d0();
    return m_cfg[1] ? (sum_term[0] | sum_term[1]) : sum_term[0];
  endfunction

  function automatic bit f_fb(int i);
    return m_q[i] & ~areset_term[i];
  endfunction

  function automatic bit f_pad();
    bit v;
    v = m_cfg[2] ? f_fb(0) : f_d0();
    return v ^ m_cfg[0];
  endfunction

  function automatic bit f_src(int i);
    return m_cfg[3+i] ? pin_clk : clk_term[i];
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic zero_inputs();
    sum_term = '0; clk_term = '0; areset_term = '0; pin_clk = 0;
    sync_preset = 0; oe_term = 0; preload_mode = 0; preload_sel = '0; pad_i = 0;
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      string t;
      t = areset_term[i] ? "R5" : m_cause[i];
      check(t, fb[i], f_fb(i));
    end
    check(m_cfg[0] ? "R8" : "R7", pad_o, f_pad());
    check("R6 oe", pad_oe, oe_term);
    check("R6 rd", pin_rd, pad_i);
  endtask

  // model update at an edge, using values stable before the edge
  task automatic model_edge();
    bit [1:0] nq;
    for (int i = 0; i < 2; i++) begin
      bit r, d;
      r = f_src(i) & ~m_prev[i];
      d = (i == 0) ? f_d0() : sum_term[1];
      nq[i] = m_q[i];
      if (areset_term[i]) begin
        nq[i] = 0; m_cause[i] = "R5";
      end else if (r) begin
        if (preload_mode) begin
          if (preload_sel == 1'(i)) begin nq[i] = pad_i; m_cause[i] = "R9"; end
          else m_cause[i] = "R9 hold";
        end else if (sync_preset) begin
          nq[i] = 1; m_cause[i] = "R10";
        end else if (m_cfg[5+i]) begin
          nq[i] = m_q[i] ^ d; m_cause[i] = "R3";
        end else begin
          nq[i] = d; m_cause[i] = "R2";
        end
      end else begin
        m_cause[i] = preload_mode ? "R9 hold" : "R4";
      end
    end
    for (int i = 0; i < 2; i++) m_prev[i] = f_src(i);
    m_q = nq;
  endtask

  task automatic do_reset(bit [6:0] c);
    @(negedge clk);
    rst_n = 0;
    zero_inputs();
    {cfg_toggle, cfg_pinclk, cfg_reg_out, cfg_merge, cfg_invert} = c;
    m_cfg = c; m_q = 0; m_prev = 0;
    m_cause[0] = "R1"; m_cause[1] = "R1";
    repeat (3) @(negedge clk);
    #1;
    check("R11 fb", fb, 0);
    check("R11 pad", pad_o, c[0]);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rand_cycle(int pl_rate, int ar_rate);
    @(negedge clk);
    sum_term     = 2'($urandom);
    clk_term     = 2'($urandom);
    pin_clk      = 1'($urandom);
    areset_term  = {($urandom % ar_rate) == 0, ($urandom % ar_rate) == 0};
    sync_preset  = ($urandom % 5) == 0;
    preload_mode = ($urandom % pl_rate) == 0;
    preload_sel  = 1'($urandom);
    pad_i        = 1'($urandom);
    oe_term      = 1'($urandom);
    // scrambled configuration pins must be ignored (R11)
    {cfg_toggle, cfg_pinclk, cfg_reg_out, cfg_merge, cfg_invert} = 7'($urandom);
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 0;
    zero_inputs();
    {cfg_toggle, cfg_pinclk, cfg_reg_out, cfg_merge, cfg_invert} = '0;

    // directed: D-type, own clock, preload plus reset term collide on reg 0
    do_reset(7'b00_00_1_0_0);
    @(negedge clk);
    preload_mode = 1; preload_sel = 0; pad_i = 1; clk_term = 2'b01; areset_term = 2'b01;
    #1; compare_all(); @(posedge clk); model_edge();
    @(negedge clk);
    zero_inputs();
    #1; check("R5 priority", fb[0], 0); compare_all(); @(posedge clk); model_edge();
    // directed: preset against data 0, then preload beats preset on reg 1
    @(negedge clk);
    clk_term = 2'b11; sync_preset = 1; sum_term = 2'b00;
    #1; compare_all(); @(posedge clk); model_edge();
    @(negedge clk);
    zero_inputs();
    #1; check("R10 preset", fb, 2'b11); compare_all(); @(posedge clk); model_edge();
    @(negedge clk);
    clk_term = 2'b11; sync_preset = 1; preload_mode = 1; preload_sel = 1; pad_i = 0;
    #1; compare_all(); @(posedge clk); model_edge();
    @(negedge clk);
    zero_inputs();
    #1; check("R9 preload sel1", fb, 2'b01); compare_all(); @(posedge clk); model_edge();

    // every configuration, random traffic
    for (int c = 0; c < 128; c++) begin
      do_reset(7'(c));
      for (int n = 0; n < 180; n++) begin
        rand_cycle((n < 90) ? 6 : 40, (n < 90) ? 10 : 50);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule